// File: doc/BRIEF.md
# Idle-Countdown SMI Generator

This block sits in the power-management corner of a chipset and runs on the PCI clock. Software reaches it through a small byte-wide register port. The port has an address, write data, a write strobe and a combinational read-data bus. Through that port software programs a tick rate and a reload value. The block then counts idle periods down to zero. When the count is used up, it latches a timer status flag and raises its SMI request. It reloads itself and keeps counting.

A second source of SMI is a write to the APM control port. That address is decoded outside the block and arrives as a one-cycle strobe. The strobe latches an APM status flag, but only while SMI generation is enabled. Both status flags are cleared by writing ones to them. The SMI request stays high while either flag is set.

The block also holds three event-enable bytes with fixed write masks. The activity events themselves are decoded elsewhere.

Register map (byte addresses):
- 0x00 control
- 0x01 SMI enable
- 0x02 to 0x04 event-enable bytes 0 to 2
- 0x05 reload
- 0x06 status

Top module: `pm_smi_timer`

## Requirements
- R1: After reset, the registers read as follows: control (0x00) is 0x08, reload (0x05) is 0x0F, and SMI enable (0x01), the event bytes (0x02 to 0x04) and status (0x06) are 0x00. `smi_req` is low.
- R2: A write to control (0x00) stores only bits 4:0. Bits 7:5 read back as zero.
- R3: The event-enable bytes apply write masks: byte 0 (0x02) keeps mask 0xFB, byte 1 (0x03) keeps 0xFF, and byte 2 (0x04) keeps 0xA0. SMI enable (0x01) stores all 8 bits.
- R4: Control bits 4:3 select the tick rate. The value 2'b10 gives a tick on every clock. The value 2'b11 gives one tick every 2^PRE_W clocks (32768 by default), counted from the last restart.
- R5: The value 2'b00 in control bits 4:3 gives one tick every 2^PRE_W × LONG_DIV clocks (32768 × 60000 by default). The value 2'b01 gives no ticks, so the countdown holds.
- R6: The countdown holds the reload value (0x05, all 8 bits writable) plus one, and it decrements on each tick. On the tick that takes it to zero, status bit 5 is set in the following cycle and the count reloads with reload plus one.
- R7: Any write to control (0x00) or to reload (0x05) reloads the countdown from the newly written reload value plus one. The same write restarts the tick timer from zero. A countdown rewritten more often than it expires never sets status bit 5.
- R8: When a strobe arrives on `apm_wr` while control bit 0 and SMI-enable bit 7 are both set, status bit 7 is set. A strobe with either bit clear leaves status bit 7 unchanged.
- R9: Status (0x06) holds only bits 7 and 5. Writing 1 to a bit clears it. A set event in the same cycle as the clear wins, and the bit stays set.
- R10: `smi_req` is high exactly while status bit 7 or status bit 5 is set.
- R11: Writes to addresses other than 0x00 to 0x06 change no register. Reads from those addresses return 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 8 | Register write data |
| reg_we | input | 1 | Register write strobe, one cycle per write |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| apm_wr | input | 1 | One-cycle strobe for a write to the APM control port |
| smi_req | output | 1 | SMI request, level |

## Verification
The assertions take three things for granted:
- `reg_we` and `apm_wr` are single-cycle strobes, sampled at the rising edge and stable around it.
- A tick rate changes only through a control write, so every change of rate comes with a restart.
- Status bit 7 has no source other than an enabled APM strobe.

The stimulus drives every input shortly after a rising edge. It moves the tick rate only by register writes. It uses the reduced prescaler and divider parameters so that the slow rates can expire within the run. It also deliberately overlaps clears with expiries, and sends APM strobes with generation off.

// File: rtl/pm_smi_pkg.sv
package pm_smi_pkg;

  localparam int DATA_W = 8;
  localparam int EVT_N  = 3;

  // register byte addresses
  localparam int A_CTRL   = 0;
  localparam int A_SMIEN  = 1;
  localparam int A_EVT0   = 2;
  localparam int A_RELOAD = A_EVT0 + EVT_N;
  localparam int A_STATUS = A_RELOAD + 1;

  localparam logic [DATA_W-1:0] CTRL_MASK   = 8'h1F;
  localparam logic [DATA_W-1:0] CTRL_RST    = 8'h08;
  localparam logic [DATA_W-1:0] RELOAD_RST  = 8'h0F;
  localparam int STAT_APM = 7;
  localparam int STAT_TMR = 5;
  localparam logic [DATA_W-1:0] STAT_MASK   = 8'hA0;

  typedef enum logic [1:0] {
    RATE_LONG = 2'b00,
    RATE_OFF  = 2'b01,
    RATE_FAST = 2'b10,
    RATE_MID  = 2'b11
  } rate_e;

  // countdown value loaded from a reload byte
  function automatic logic [DATA_W:0] load_value(input logic [DATA_W-1:0] r);
    return {1'b0, r} + {{DATA_W{1'b0}}, 1'b1};
  endfunction

  // write mask of each event-enable byte
  function automatic logic [DATA_W-1:0] evt_mask(input int idx);
    case (idx)
      0:       return 8'hFB;
      1:       return 8'hFF;
      default: return 8'hA0;
    endcase
  endfunction

  // write-one-to-clear with set priority
  function automatic logic [DATA_W-1:0] status_next(input logic [DATA_W-1:0] cur,
                                                    input logic [DATA_W-1:0] clr,
                                                    input logic [DATA_W-1:0] set);
    return ((cur & ~clr) | set) & STAT_MASK;
  endfunction

endpackage

// File: rtl/pm_tick_gen.sv
module pm_tick_gen
  import pm_smi_pkg::*;
#(
  parameter int PRE_W    = 15,
  parameter int LONG_DIV = 60000
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  restart,
  input  rate_e rate,
  output logic  tick
);
  localparam int DIV_W = $clog2(LONG_DIV + 1);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(LONG_DIV - 1);

  logic [PRE_W-1:0] pre_cnt;
  logic [DIV_W-1:0] div_cnt;
  logic             pre_wrap;
  logic             div_wrap;

  assign pre_wrap = &pre_cnt;
  assign div_wrap = (div_cnt == DIV_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      div_cnt <= '0;
    end else if (restart) begin
      pre_cnt <= '0;
      div_cnt <= '0;
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
      if (pre_wrap) div_cnt <= div_wrap ? '0 : div_cnt + 1'b1;
    end
  end

  always_comb begin
    case (rate)
      RATE_FAST: tick = 1'b1;
      RATE_MID:  tick = pre_wrap;
      RATE_LONG: tick = pre_wrap && div_wrap;
      default:   tick = 1'b0;
    endcase
  end

  // R4
  mid_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && rate == RATE_MID && !restart) |=> !(tick && rate == RATE_MID));

endmodule

// File: rtl/pm_countdown.sv
module pm_countdown
  import pm_smi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              tick,
  input  rate_e             rate,
  input  logic [DATA_W-1:0] reload_cur,
  input  logic [DATA_W-1:0] reload_nxt,
  output logic              expire,
  output logic [DATA_W:0]   count
);
  localparam logic [DATA_W:0] ONE = {{DATA_W{1'b0}}, 1'b1};

  assign expire = tick && !restart && (count == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= load_value(RELOAD_RST);
    else if (restart) count <= load_value(reload_nxt);
    else if (tick)    count <= expire ? load_value(reload_cur) : count - ONE;
  end

  // R6
  count_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count != '0);

  // R7
  restart_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> count == load_value(reload_cur));

  // R5
  off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rate == RATE_OFF && !restart) |=> $stable(count));

endmodule

// File: rtl/pm_regs.sv
module pm_regs
  import pm_smi_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              we,
  input  logic              apm_wr,
  input  logic              set_timer,
  output logic [DATA_W-1:0] rdata,
  output rate_e             rate,
  output logic              restart,
  output logic [DATA_W-1:0] reload_cur,
  output logic [DATA_W-1:0] reload_nxt,
  output logic              smi_req
);
  localparam logic [ADDR_W-1:0] AD_CTRL   = ADDR_W'(A_CTRL);
  localparam logic [ADDR_W-1:0] AD_SMIEN  = ADDR_W'(A_SMIEN);
  localparam logic [ADDR_W-1:0] AD_RELOAD = ADDR_W'(A_RELOAD);
  localparam logic [ADDR_W-1:0] AD_STATUS = ADDR_W'(A_STATUS);

  logic [DATA_W-1:0]       ctrl_q;
  logic [DATA_W-1:0]       smien_q;
  logic [DATA_W-1:0]       reload_q;
  logic [DATA_W-1:0]       status_q;
  logic [EVT_N*DATA_W-1:0] evt_flat;
  logic                    ctrl_wr;
  logic                    reload_wr;
  logic                    gen_en;
  logic                    apm_set;
  logic [DATA_W-1:0]       stat_set;
  logic [DATA_W-1:0]       stat_clr;

  assign ctrl_wr    = we && (addr == AD_CTRL);
  assign reload_wr  = we && (addr == AD_RELOAD);
  assign restart    = ctrl_wr || reload_wr;
  assign rate       = rate_e'(ctrl_q[4:3]);
  assign gen_en     = ctrl_q[0] && smien_q[7];
  assign apm_set    = apm_wr && gen_en;
  assign reload_cur = reload_q;
  assign reload_nxt = reload_wr ? wdata : reload_q;

  always_comb begin
    stat_set           = '0;
    stat_set[STAT_APM] = apm_set;
    stat_set[STAT_TMR] = set_timer;
    stat_clr           = (we && addr == AD_STATUS) ? wdata : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= CTRL_RST;
      smien_q  <= '0;
      reload_q <= RELOAD_RST;
      status_q <= '0;
    end else begin
      if (ctrl_wr)                   ctrl_q   <= wdata & CTRL_MASK;
      if (we && addr == AD_SMIEN)    smien_q  <= wdata;
      if (reload_wr)                 reload_q <= wdata;
      status_q <= status_next(status_q, stat_clr, stat_set);
    end
  end

  for (genvar gi = 0; gi < EVT_N; gi++) begin : g_evt
    localparam logic [ADDR_W-1:0] AD_ME = ADDR_W'(A_EVT0 + gi);
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 q <= '0;
      else if (we && addr == AD_ME) q <= wdata & evt_mask(gi);
    end
    assign evt_flat[gi*DATA_W +: DATA_W] = q;
  end

  always_comb begin
    rdata = '0;
    if (addr == AD_CTRL)   rdata = ctrl_q;
    if (addr == AD_SMIEN)  rdata = smien_q;
    if (addr == AD_RELOAD) rdata = reload_q;
    if (addr == AD_STATUS) rdata = status_q;
    for (int i = 0; i < EVT_N; i++)
      if (addr == ADDR_W'(A_EVT0 + i)) rdata = evt_flat[i*DATA_W +: DATA_W];
  end

  assign smi_req = |(status_q & STAT_MASK);

  // R6
  timer_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_timer |=> status_q[STAT_TMR]);

  // R8
  apm_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (apm_wr && !gen_en && !status_q[STAT_APM]) |=> !status_q[STAT_APM]);

  // R10
  smi_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(smi_req) |-> $past(set_timer || apm_set));

  // R2
  ctrl_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[7:5] == 3'b000);

endmodule

// File: rtl/pm_smi_timer.sv
module pm_smi_timer
  import pm_smi_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int PRE_W    = 15,
  parameter int LONG_DIV = 60000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  input  logic              reg_we,
  output logic [7:0]        reg_rdata,
  input  logic              apm_wr,
  output logic              smi_req
);
  rate_e             rate;
  logic              restart;
  logic              tick;
  logic              expire;
  logic [DATA_W-1:0] reload_cur;
  logic [DATA_W-1:0] reload_nxt;
  logic [DATA_W:0]   count;

  pm_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wdata(reg_wdata), .we(reg_we),
    .apm_wr(apm_wr), .set_timer(expire), .rdata(reg_rdata), .rate(rate),
    .restart(restart), .reload_cur(reload_cur), .reload_nxt(reload_nxt),
    .smi_req(smi_req)
  );

  pm_tick_gen #(.PRE_W(PRE_W), .LONG_DIV(LONG_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .restart(restart), .rate(rate), .tick(tick)
  );

  pm_countdown u_cnt (
    .clk(clk), .rst_n(rst_n), .restart(restart), .tick(tick), .rate(rate),
    .reload_cur(reload_cur), .reload_nxt(reload_nxt), .expire(expire),
    .count(count)
  );

  // R7
  restart_no_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |-> !expire);

endmodule

// File: tb/tb_pm_smi_timer.sv
module tb_pm_smi_timer;
  localparam int CLK_PERIOD = 10;
  localparam int PRE        = 16;
  localparam int DIV        = 3;

  logic       clk = 0;
  logic       rst_n;
  logic [7:0] reg_addr;
  logic [7:0] reg_wdata;
  logic       reg_we;
  logic [7:0] reg_rdata;
  logic       apm_wr;
  logic       smi_req;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  // reference model state
  int m_ctrl, m_smien, m_reload, m_status, m_count, m_elapsed;
  int m_evt [3];

  always #(CLK_PERIOD/2) clk = ~clk;

  pm_smi_timer #(.ADDR_W(8), .PRE_W(4), .LONG_DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata), .apm_wr(apm_wr), .smi_req(smi_req)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int m_read(input int a);
    case (a)
      0: return m_ctrl;
      1: return m_smien;
      2, 3, 4: return m_evt[a-2];
      5: return m_reload;
      6: return m_status;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(input int a);
    case (a)
      0: return "R2 control";
      1, 2, 3, 4: return "R3 enables";
      5: return "R6 reload";
      6: return "R9 status";
      default: return "R11 unmapped";
    endcase
  endfunction

  // behavioural model, advanced on every rising edge
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_ctrl = 8; m_smien = 0; m_reload = 15; m_status = 0;
      m_count = 16; m_elapsed = 0;
      foreach (m_evt[i]) m_evt[i] = 0;
    end else begin
      int rate, set, clr;
      bit tk, rs, gen;
      rate = (m_ctrl >> 3) & 3;
      case (rate)
        2: tk = 1;
        3: tk = (m_elapsed % PRE) == PRE - 1;
        0: tk = (m_elapsed % (PRE*DIV)) == PRE*DIV - 1;
        default: tk = 0;
      endcase
      rs  = reg_we && (reg_addr == 0 || reg_addr == 5);
      gen = (m_ctrl & 1) && (m_smien & 128);
      set = 0;
      if (!rs && tk) begin
        if (m_count == 1) begin set |= 32; m_count = m_reload + 1; end
        else m_count--;
      end
      if (apm_wr && gen) set |= 128;
      clr = (reg_we && reg_addr == 6) ? reg_wdata : 0;
      if (reg_we) begin
        case (reg_addr)
          0: m_ctrl   = reg_wdata & 8'h1F;
          1: m_smien  = reg_wdata;
          2: m_evt[0] = reg_wdata & 8'hFB;
          3: m_evt[1] = reg_wdata;
          4: m_evt[2] = reg_wdata & 8'hA0;
          5: m_reload = reg_wdata;
          default: ;
        endcase
      end
      m_status = ((m_status & ~clr) | set) & 8'hA0;
      if (rs) begin m_count = m_reload + 1; m_elapsed = 0; end
      else m_elapsed++;
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && cyc > 1) begin
      chk(tag_of(reg_addr), reg_rdata, m_read(reg_addr));
      chk("R10 smi_req", smi_req, (m_status & 8'hA0) != 0);
    end
  end

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc == 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  task automatic wr(input int a, input int d);
    @(posedge clk); #1;
    reg_addr = 8'(a); reg_wdata = 8'(d); reg_we = 1;
    @(posedge clk); #1;
    reg_we = 0;
  endtask

  task automatic rd_chk(input int a, input int exp, input string tag);
    @(posedge clk); #1;
    reg_addr = 8'(a);
    @(negedge clk);
    chk(tag, reg_rdata, exp);
  endtask

  task automatic apm_pulse;
    @(posedge clk); #1; apm_wr = 1;
    @(posedge clk); #1; apm_wr = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    rst_n = 0; reg_addr = 0; reg_wdata = 0; reg_we = 0; apm_wr = 0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset values
    rd_chk(0, 8'h08, "R1 ctrl reset");
    rd_chk(1, 0, "R1 smien reset");
    rd_chk(2, 0, "R1 evt0 reset");
    rd_chk(4, 0, "R1 evt2 reset");
    rd_chk(5, 8'h0F, "R1 reload reset");
    rd_chk(6, 0, "R1 status reset");
    chk("R1 smi_req reset", smi_req, 0);
    idle(40);
    rd_chk(6, 0, "R1 timer stopped after reset");

    // R2 control mask
    wr(0, 8'hFF);
    rd_chk(0, 8'h1F, "R2 ctrl masked");
    // R3 enables
    wr(1, 8'hFF); rd_chk(1, 8'hFF, "R3 smien full");
    wr(2, 8'hFF); rd_chk(2, 8'hFB, "R3 evt0 mask");
    wr(3, 8'hFF); rd_chk(3, 8'hFF, "R3 evt1 mask");
    wr(4, 8'hFF); rd_chk(4, 8'hA0, "R3 evt2 mask");

    // R8 enabled APM strobe
    wr(0, 8'h09);
    wr(6, 8'hFF);
    apm_pulse();
    rd_chk(6, 8'h80, "R8 apm sets bit7");
    chk("R10 smi_req from apm", smi_req, 1);
    // R9 clear
    wr(6, 8'h80);
    rd_chk(6, 0, "R9 w1c bit7");
    // R8 generation disabled by smien bit7
    wr(1, 8'h7F);
    apm_pulse();
    rd_chk(6, 0, "R8 apm ignored smien off");
    wr(1, 8'h80); wr(0, 8'h08);
    apm_pulse();
    rd_chk(6, 0, "R8 apm ignored ctrl bit0 off");

    // R4 fast rate, R6 expiry timing
    wr(6, 8'hA0);
    wr(0, 8'h10);
    wr(5, 3);
    reg_addr = 6;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R6 no expiry before reload+1 ticks", reg_rdata & 8'h20, 0);
    @(posedge clk); @(negedge clk);
    chk("R6 expiry after reload+1 ticks", reg_rdata & 8'h20, 8'h20);
    chk("R10 smi_req from timer", smi_req, 1);
    // R9 clear overlapping expiries
    for (int i = 0; i < 12; i++) wr(6, 8'h20);
    idle(10);

    // R7 restarts prevent expiry
    wr(5, 5);
    wr(6, 8'hA0);
    for (int i = 0; i < 10; i++) begin wr(0, 8'h10); idle(1); end
    rd_chk(6, 0, "R7 restarts block expiry");

    // R4 mid rate
    wr(5, 0);
    wr(0, 8'h18);
    wr(6, 8'hA0);
    reg_addr = 6;
    idle(8);
    rd_chk(6, 0, "R4 mid rate not yet");
    idle(30);
    rd_chk(6, 8'h20, "R4 mid rate expiry");

    // R5 long rate
    wr(5, 1);
    wr(0, 8'h00);
    wr(6, 8'hA0);
    reg_addr = 6;
    idle(60);
    rd_chk(6, 0, "R5 long rate not yet");
    idle(60);
    rd_chk(6, 8'h20, "R5 long rate expiry");

    // R5 off rate
    wr(0, 8'h08);
    wr(6, 8'hA0);
    idle(120);
    rd_chk(6, 0, "R5 off rate no expiry");

    // R6 reload full width
    wr(5, 8'hA5);
    rd_chk(5, 8'hA5, "R6 reload all bits");

    // R11 unmapped
    wr(7, 8'hFF); wr(8'h80, 8'hFF); wr(8'hFF, 8'hFF);
    rd_chk(7, 0, "R11 unmapped read 07");
    rd_chk(8'hFF, 0, "R11 unmapped read FF");
    rd_chk(0, 8'h08, "R11 ctrl untouched");
    rd_chk(5, 8'hA5, "R11 reload untouched");
    rd_chk(6, 0, "R11 status untouched");

    idle(5);
    finish_run();
  end

endmodule